// File: doc/BRIEF.md
# Asynchronous SRAM Lane Controller

This block sits between a clocked host and an external asynchronous static RAM with 262,144 words of 16 bits. The host hands over one request at a time on a valid/ready port. Each request carries an address, a write word, a two-bit lane mask and a read/write flag. The controller turns the request into a chip-enable / output-enable / write-enable sequence on the RAM pins. It drives the two active-low byte-lane enables from the mask. For reads it returns the captured word with a one-cycle valid pulse.

Every timing minimum of the RAM is a nanosecond parameter: write cycle, write pulse, data setup, read cycle, address access and output-enable access. The controller rounds each one up to whole clock periods. The data bus is split into an output word, an output-enable and an input word, which the chip pad ring joins into a tri-state pin. While no request is in flight, the controller holds the RAM deselected in standby.

Top module: `sram_lane_ctrl`

## Requirements
- R1: After reset and whenever `req_ready` is 1, the outputs `sram_ce_n`, `sram_oe_n`, `sram_we_n`, `sram_lb_n` and `sram_ub_n` are all 1, and both `sram_dq_oe` and `rsp_valid` are 0 except as R10 allows.
- R2: A request presented while `req_ready` is 0 is not taken. It changes neither `sram_addr` nor the RAM contents.
- R3: While `sram_ce_n` is 0, `sram_lb_n` equals the inverse of mask bit 0 and `sram_ub_n` equals the inverse of mask bit 1. Bit 0 selects data bits 7:0 and bit 1 selects bits 15:8.
- R4: A write holds `sram_we_n` low for exactly P cycles, where P = max(ceil(tWP), ceil(tDS), ceil(tWC) - 2) in clock periods. This is 3 at the defaults. During the write `sram_ce_n` is low and `sram_oe_n` stays high.
- R5: `sram_dq_oe` is 1 only while `sram_oe_n` is 1. It rises in the first cycle of a write. It stays on through the cycle after `sram_we_n` returns high, so it covers P+2 cycles.
- R6: A write keeps `req_ready` low for exactly P+2 cycles after the accepting edge.
- R7: A read holds `sram_ce_n` and `sram_oe_n` low with `sram_we_n` high for exactly D cycles, where D = max(ceil(tRC), ceil(tAA), ceil(tOE)). This is 3 at the defaults. The data is sampled at the edge that ends the last of these cycles.
- R8: After a read, `rsp_valid` is 1 for exactly one cycle. `rsp_rdata` holds the sampled lanes, and any lane whose mask bit is 0 reads as zero.
- R9: After a read there is one cycle with `sram_ce_n` and `sram_oe_n` high, during which `rsp_valid` is 1. `req_ready` is low for D+1 cycles in total.
- R10: A request with mask 00 is taken without any RAM cycle, and `req_ready` stays 1. For a read, `rsp_valid` is 1 in the next cycle with `rsp_rdata` = 0.
- R11: `sram_addr` does not change while `sram_ce_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write word |
| req_mask | input | 2 | Lane mask, bit 0 low byte, bit 1 high byte |
| rsp_valid | output | 1 | Read word valid, one cycle |
| rsp_rdata | output | 16 | Read word |
| sram_addr | output | 18 | RAM address |
| sram_dq_o | output | 16 | Word driven to the RAM data pins |
| sram_dq_oe | output | 1 | Enable of the data pin drivers |
| sram_dq_i | input | 16 | Word seen on the RAM data pins |
| sram_ce_n | output | 1 | RAM chip enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_lb_n | output | 1 | Low byte lane enable, active low |
| sram_ub_n | output | 1 | High byte lane enable, active low |

## Verification
Two events can share a cycle. One is the response pulse of a zero-mask read, which needs no RAM cycle. The other is the acceptance of the next request, since `req_ready` never drops for that read. The bench keeps `req_valid` high across the two requests: first a zero-mask read, then at once a full write. In the cycle between them it checks that `rsp_valid` is 1 with zero data while `req_ready` is also 1. It then checks that the write runs with its full pulse and occupancy, and that a later read returns the written word.

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl #(
  parameter int ADDR_W  = 18,
  parameter int CLK_NS  = 20,
  parameter int T_WC_NS = 55,
  parameter int T_WP_NS = 45,
  parameter int T_DS_NS = 25,
  parameter int T_RC_NS = 55,
  parameter int T_AA_NS = 55,
  parameter int T_OE_NS = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [15:0]       req_wdata,
  input  logic [1:0]        req_mask,
  output logic              rsp_valid,
  output logic [15:0]       rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [15:0]       sram_dq_o,
  output logic              sram_dq_oe,
  input  logic [15:0]       sram_dq_i,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic              sram_lb_n,
  output logic              sram_ub_n
);

  function automatic int to_cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int PUL_C = imax(imax(to_cyc(T_WP_NS), to_cyc(T_DS_NS)), imax(to_cyc(T_WC_NS) - 2, 1));
  localparam int RD_C  = imax(imax(to_cyc(T_RC_NS), to_cyc(T_AA_NS)), to_cyc(T_OE_NS));
  localparam int CNT_W = $clog2(imax(PUL_C, RD_C) + 1);

  typedef enum logic [2:0] {S_IDLE, S_WSET, S_WPUL, S_WHLD, S_RACC, S_REND} st_t;

  st_t              st, nxt;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       m_q;

  assign req_ready = (st == S_IDLE);

  wire accept = req_valid && req_ready;
  wire go     = accept && (req_mask != 2'b00);
  wire last   = (cnt == '0);

  always_comb begin
    nxt = st;
    case (st)
      S_IDLE:  if (go) nxt = req_write ? S_WSET : S_RACC;
      S_WSET:  nxt = S_WPUL;
      S_WPUL:  if (last) nxt = S_WHLD;
      S_WHLD:  nxt = S_IDLE;
      S_RACC:  if (last) nxt = S_REND;
      S_REND:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  wire [1:0] m_nxt  = go ? req_mask : m_q;
  wire       bus_on = (nxt inside {S_WSET, S_WPUL, S_WHLD, S_RACC});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      m_q        <= 2'b00;
      sram_addr  <= '0;
      sram_dq_o  <= '0;
      sram_ce_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_lb_n  <= 1'b1;
      sram_ub_n  <= 1'b1;
      sram_dq_oe <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      st <= nxt;
      if (nxt != st)
        cnt <= (nxt == S_WPUL) ? CNT_W'(PUL_C - 1) : CNT_W'(RD_C - 1);
      else if (!last)
        cnt <= cnt - 1'b1;
      if (go) begin
        m_q       <= req_mask;
        sram_addr <= req_addr;
        sram_dq_o <= req_wdata;
      end
      sram_ce_n  <= !bus_on;
      sram_oe_n  <= (nxt != S_RACC);
      sram_we_n  <= (nxt != S_WPUL);
      sram_dq_oe <= (nxt inside {S_WSET, S_WPUL, S_WHLD});
      sram_lb_n  <= !(bus_on && m_nxt[0]);
      sram_ub_n  <= !(bus_on && m_nxt[1]);
      rsp_valid  <= 1'b0;
      if (st == S_RACC && last) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= {m_q[1] ? sram_dq_i[15:8] : 8'h00, m_q[0] ? sram_dq_i[7:0] : 8'h00};
      end else if (accept && !req_write && req_mask == 2'b00) begin
        rsp_valid <= 1'b1;
        rsp_rdata <= '0;
      end
    end
  end

endmodule

module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              ce_n,
  input logic              oe_n,
  input logic              we_n,
  input logic              lb_n,
  input logic              ub_n,
  input logic              dq_oe,
  input logic [ADDR_W-1:0] addr
);

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ce_n && oe_n && we_n && lb_n && ub_n && !dq_oe)); // R1

  AST_LANE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !(lb_n && ub_n)); // R3

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ce_n && oe_n && dq_oe)); // R4

  AST_NO_BUS_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n); // R5

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> dq_oe); // R5

  AST_READ_WE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (we_n && !ce_n)); // R7

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !req_ready) |=> !rsp_valid); // R8

  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !$past(ce_n)) |-> $stable(addr)); // R11

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n), .lb_n(sram_lb_n),
  .ub_n(sram_ub_n), .dq_oe(sram_dq_oe), .addr(sram_addr)
);

// File: tb/tb_sram_lane_ctrl.sv
`timescale 1ns/1ps
module tb_sram_lane_ctrl;

  localparam int PUL_E = 3;
  localparam int RD_E  = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        req_ready, rsp_valid, dq_oe, ce_n, oe_n, we_n, lb_n, ub_n;
  logic [15:0] rsp_rdata, dq_o, dq_i;
  logic [17:0] sram_addr;

  always #10 clk = ~clk;

  sram_lane_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr), .sram_dq_o(dq_o),
    .sram_dq_oe(dq_oe), .sram_dq_i(dq_i), .sram_ce_n(ce_n), .sram_oe_n(oe_n),
    .sram_we_n(we_n), .sram_lb_n(lb_n), .sram_ub_n(ub_n)
  );

  logic [15:0] mem [0:255];
  initial for (int i = 0; i < 256; i++) mem[i] = 16'h0000;

  always @(posedge we_n) begin
    if (ce_n === 1'b0) begin
      if (!lb_n) mem[sram_addr[7:0]][7:0]  = dq_oe ? dq_o[7:0]  : 8'hxx;
      if (!ub_n) mem[sram_addr[7:0]][15:8] = dq_oe ? dq_o[15:8] : 8'hxx;
    end
  end

  assign dq_i = (!ce_n && !oe_n && we_n) ?
                {ub_n ? 8'hA5 : mem[sram_addr[7:0]][15:8], lb_n ? 8'h5A : mem[sram_addr[7:0]][7:0]} : 16'h0000;

  int checks = 0, errors = 0;
  int n_busy, n_we, n_oe, n_drv, n_ce, n_clash, n_lane, n_addr, n_rsp;
  logic [15:0] rsp_q;
  logic        rsp_ce_q;
  logic [1:0]  exp_mask = 2'b00;
  logic        prev_ce_low = 1'b0;
  logic [17:0] prev_addr = '0;

  task automatic clear_mon();
    n_busy = 0; n_we = 0; n_oe = 0; n_drv = 0; n_ce = 0;
    n_clash = 0; n_lane = 0; n_addr = 0; n_rsp = 0; rsp_q = 16'hFFFF; rsp_ce_q = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!req_ready) n_busy++;
      if (!we_n) n_we++;
      if (!oe_n) n_oe++;
      if (dq_oe) n_drv++;
      if (!ce_n) n_ce++;
      if (dq_oe && !oe_n) n_clash++;
      if (!ce_n && (lb_n != !exp_mask[0] || ub_n != !exp_mask[1])) n_lane++;
      if (!ce_n && prev_ce_low && sram_addr != prev_addr) n_addr++;
      prev_ce_low = !ce_n;
      prev_addr   = sram_addr;
      if (rsp_valid) begin n_rsp++; rsp_q = rsp_rdata; rsp_ce_q = ce_n; end
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic check_idle(string req);
    check(req, {ce_n, oe_n, we_n, lb_n, ub_n, dq_oe, req_ready}, 7'b1111101);
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!req_ready && guard < 100) begin @(negedge clk); guard++; end
    #1;
  endtask

  task automatic issue(logic wr, logic [17:0] a, logic [15:0] d, logic [1:0] m);
    @(negedge clk); #1;
    clear_mon();
    exp_mask = m;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk); #1;
    req_valid = 1'b0;
    req_addr = 18'h3FFFF; req_wdata = 16'hFFFF;
    wait_ready();
  endtask

  task automatic do_write(logic [17:0] a, logic [15:0] d, logic [1:0] m);
    issue(1'b1, a, d, m);
    check("R4 we low cycles", n_we, PUL_E);
    check("R4 oe stays high", n_oe, 0);
    check("R5 driver cycles", n_drv, PUL_E + 2);
    check("R5 no clash", n_clash, 0);
    check("R6 busy cycles", n_busy, PUL_E + 2);
    check("R3 lane enables", n_lane, 0);
    check("R11 addr stable", n_addr, 0);
    check_idle("R1 idle after write");
  endtask

  task automatic do_read(logic [17:0] a, logic [1:0] m, logic [15:0] exp);
    issue(1'b0, a, 16'h0000, m);
    check("R7 oe low cycles", n_oe, RD_E);
    check("R7 no write strobe", n_we + n_drv, 0);
    check("R9 busy cycles", n_busy, RD_E + 1);
    check("R9 ce high in rsp cycle", rsp_ce_q, 1);
    check("R8 rsp pulse count", n_rsp, 1);
    check("R8 rsp data", rsp_q, exp);
    check("R3 lane enables", n_lane, 0);
    check("R11 addr stable", n_addr, 0);
    check_idle("R1 idle after read");
  endtask

  task automatic zero_write_test();
    issue(1'b1, 18'h00012, 16'h9999, 2'b00);
    check("R10 zero mask no busy", n_busy, 0);
    check("R10 zero mask no ce", n_ce, 0);
    check("R10 zero write no rsp", n_rsp, 0);
    do_read(18'h00012, 2'b11, 16'h5634);
  endtask

  task automatic zero_read_then_write_test();
    @(negedge clk); #1;
    clear_mon();
    exp_mask = 2'b11;
    req_valid = 1'b1; req_write = 1'b0; req_addr = 18'h00012; req_mask = 2'b00;
    @(negedge clk);
    check("R10 rsp same cycle", rsp_valid, 1);
    check("R10 rsp zero data", rsp_rdata, 0);
    check("R10 ready kept", req_ready, 1);
    #1;
    req_write = 1'b1; req_addr = 18'h00020; req_wdata = 16'hC3D4; req_mask = 2'b11;
    @(negedge clk); #1;
    req_valid = 1'b0;
    wait_ready();
    check("R10 rsp count", n_rsp, 1);
    check("R6 busy after zero read", n_busy, PUL_E + 2);
    check("R4 we after zero read", n_we, PUL_E);
    do_read(18'h00020, 2'b11, 16'hC3D4);
  endtask

  task automatic busy_ignore_test();
    @(negedge clk); #1;
    clear_mon();
    exp_mask = 2'b11;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00030; req_wdata = 16'h1111; req_mask = 2'b11;
    @(negedge clk); #1;
    req_addr = 18'h00031; req_wdata = 16'h2222;
    @(negedge clk); #1;
    @(negedge clk); #1;
    req_valid = 1'b0;
    wait_ready();
    check("R2 single busy window", n_busy, PUL_E + 2);
    check("R2 addr untouched", n_addr, 0);
    do_read(18'h00030, 2'b11, 16'h1111);
    do_read(18'h00031, 2'b11, 16'h0000);
  endtask

  logic done = 1'b0;

  initial begin
    clear_mon();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 reset state");
    check("R1 no rsp after reset", rsp_valid, 0);
    do_write(18'h00012, 16'hBEEF, 2'b11);
    do_read (18'h00012, 2'b11, 16'hBEEF);
    do_write(18'h00012, 16'h1234, 2'b01);
    do_read (18'h00012, 2'b11, 16'hBE34);
    do_write(18'h00012, 16'h5600, 2'b10);
    do_read (18'h00012, 2'b10, 16'h5600);
    do_read (18'h00012, 2'b01, 16'h0034);
    do_write(18'h3FF01, 16'hA1B2, 2'b11);
    do_read (18'h3FF01, 2'b11, 16'hA1B2);
    zero_write_test();
    zero_read_then_write_test();
    busy_ignore_test();
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule